// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Almost Thresholds

This block moves data words from a producer on one clock to a consumer on an unrelated clock. Each side advances a binary pointer in its own domain. The pointer is registered in Gray code, passed through a two-flop synchronizer into the opposite domain, and turned back into binary there. The receiving side subtracts it from its own pointer to get a fill count.

All four status flags are derived from those fill counts and are registered. The write domain produces full and almost-full. The read domain produces empty and almost-empty. Both almost levels are inputs and may change while the FIFO runs. No request strobe ever crosses between the clocks. A flag therefore never depends on catching a one-cycle pulse. Synchronizer delay can only hold a flag asserted longer than needed; it can never release it early.

The head word is always visible on the read data port while the FIFO is not empty. Asserting the read enable consumes that word. Each side has an active-low reset with asynchronous assertion and synchronous release. The reset clears that side's pointer, its synchronizer stages and its flags.

Top module: `xclk_fifo`

## Requirements
- R1: After reset, rd_empty = 1, rd_aempty = 1, wr_full = 0 and wr_afull = 0.
- R2: Words leave in the order they were accepted. While rd_empty = 0, rd_data shows the oldest unread word, and a read (rd_en = 1 at a read clock edge) moves to the next one.
- R3: After a word is written into an empty FIFO, rd_empty falls within 5 read clock cycles, and never before a word is stored.
- R4: wr_full rises at the write clock edge that accepts the DEPTH-th stored word (DEPTH = 2^ADDR_W). The number of stored words never exceeds DEPTH. After reads free space, wr_full falls within 6 write clock cycles.
- R5: A write with wr_full = 1 is ignored. No word is stored and the write pointer does not move.
- R6: A read with rd_empty = 1 is ignored, and the read pointer does not move.
- R7: wr_afull is 1 exactly when (DEPTH minus the write-side fill count) is less than or equal to wr_afull_lvl. The write-side fill count includes the current write.
- R8: rd_aempty is 1 exactly when the read-side fill count is less than or equal to rd_aempty_lvl. The read-side fill count is the synchronized write pointer minus the read pointer after the current read.
- R9: The Gray-coded pointers sent across domains change by at most one bit per clock of their own domain.
- R10: A change of wr_afull_lvl or rd_aempty_lvl takes effect on the flag at the next clock edge of that flag's domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| wr_afull_lvl | input | ADDR_W+1 | Free-slot level at or below which wr_afull is set |
| wr_full | output | 1 | FIFO full (write domain) |
| wr_afull | output | 1 | FIFO almost full (write domain) |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| rd_en | input | 1 | Read request, consumes the head word |
| rd_data | output | DATA_W | Head word |
| rd_aempty_lvl | input | ADDR_W+1 | Fill level at or below which rd_aempty is set |
| rd_empty | output | 1 | FIFO empty (read domain) |
| rd_aempty | output | 1 | FIFO almost empty (read domain) |

## Verification
The hardest states to reach are the two exact-boundary transitions under synchronizer lag. One is the write that lands the last free slot while the read domain has not yet seen any fill. The other is the almost-empty edge at exactly the threshold count. The stimulus fills the FIFO in an unbroken write burst from a settled empty state, so the full edge falls on a known write. It then adds extra writes while full and drains word by word against a queue model. The almost thresholds are approached one word at a time and retuned on the fly at the boundary. Reads hammered into an empty FIFO are followed by a single write, so a wrongly moved read pointer shows up as a wrong word.

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   wr_afull_lvl,
  output logic              wr_full,
  output logic              wr_afull,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W:0]   rd_aempty_lvl,
  output logic              rd_empty,
  output logic              rd_aempty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  typedef logic [PW-1:0] ptr_t;
  localparam ptr_t CAP = ptr_t'(DEPTH);

  function automatic ptr_t to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(input ptr_t g);
    ptr_t b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  // write domain
  logic [1:0] wrst_q;
  logic       wrst_n;
  ptr_t       wbin, wgray, wbin_nx, rg_q1, rg_q2, rbin_w, wfill_nx;
  logic       wr_go;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) wrst_q <= '0;
    else           wrst_q <= {wrst_q[0], 1'b1};
  assign wrst_n = wrst_q[1];

  assign wr_go    = wr_en & ~wr_full;
  assign wbin_nx  = wbin + ptr_t'(wr_go);
  assign rbin_w   = from_gray(rg_q2);
  assign wfill_nx = wbin_nx - rbin_w;

  always_ff @(posedge wr_clk or negedge wrst_n)
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rg_q1    <= '0;
      rg_q2    <= '0;
      wr_full  <= 1'b0;
      wr_afull <= 1'b0;
    end else begin
      wbin     <= wbin_nx;
      wgray    <= to_gray(wbin_nx);
      rg_q1    <= rgray;
      rg_q2    <= rg_q1;
      wr_full  <= (wfill_nx == CAP);
      wr_afull <= ((CAP - wfill_nx) <= wr_afull_lvl);
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[ADDR_W-1:0]] <= wr_data;

  // read domain
  logic [1:0] rrst_q;
  logic       rrst_n;
  ptr_t       rbin, rgray, rbin_nx, wg_q1, wg_q2, wbin_r, rfill_nx;
  logic       rd_go;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) rrst_q <= '0;
    else           rrst_q <= {rrst_q[0], 1'b1};
  assign rrst_n = rrst_q[1];

  assign rd_go    = rd_en & ~rd_empty;
  assign rbin_nx  = rbin + ptr_t'(rd_go);
  assign wbin_r   = from_gray(wg_q2);
  assign rfill_nx = wbin_r - rbin_nx;

  always_ff @(posedge rd_clk or negedge rrst_n)
    if (!rrst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      wg_q1     <= '0;
      wg_q2     <= '0;
      rd_empty  <= 1'b1;
      rd_aempty <= 1'b1;
    end else begin
      rbin      <= rbin_nx;
      rgray     <= to_gray(rbin_nx);
      wg_q1     <= wgray;
      wg_q2     <= wg_q1;
      rd_empty  <= (rfill_nx == '0);
      rd_aempty <= (rfill_nx <= rd_aempty_lvl);
    end

  assign rd_data = mem[rbin[ADDR_W-1:0]];
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int ADDR_W = 4
) (
  input logic            wr_clk,
  input logic            wrst_n,
  input logic            wr_en,
  input logic            wr_full,
  input logic [ADDR_W:0] wbin,
  input logic [ADDR_W:0] wgray,
  input logic [ADDR_W:0] rbin_w,
  input logic            rd_clk,
  input logic            rrst_n,
  input logic            rd_en,
  input logic            rd_empty,
  input logic [ADDR_W:0] rbin,
  input logic [ADDR_W:0] rgray,
  input logic [ADDR_W:0] wbin_r
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W + 1)'(1 << ADDR_W);

  // R9
  wgray_onebit_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R9
  rgray_onebit_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R4
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wbin - rbin_w) <= CAP);
  // R3
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (wbin_r - rbin) <= CAP);
  // R5
  full_hold_chk: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_full && wr_en) |=> $stable(wbin));
  // R6
  empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_empty && rd_en) |=> $stable(rbin));
endmodule

bind xclk_fifo xclk_fifo_chk #(.ADDR_W(ADDR_W)) chk_i (
  .wr_clk(wr_clk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_full(wr_full),
  .wbin(wbin), .wgray(wgray), .rbin_w(rbin_w),
  .rd_clk(rd_clk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_empty(rd_empty),
  .rbin(rbin), .rgray(rgray), .wbin_r(wbin_r)
);

// File: tb/xclk_fifo_tb_top.sv
module xclk_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [ADDR_W:0] wr_afull_lvl = 2, rd_aempty_lvl = 2;
  logic wr_full, wr_afull, rd_empty, rd_aempty;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DATA_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  xclk_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_afull_lvl(wr_afull_lvl), .wr_full(wr_full), .wr_afull(wr_afull),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_aempty_lvl(rd_aempty_lvl), .rd_empty(rd_empty), .rd_aempty(rd_aempty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_wr(input int n);
    for (int i = 0; i < n; i++) @(negedge wr_clk);
  endtask

  task automatic wait_rd(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  task automatic settle();
    wait_wr(8);
    wait_rd(8);
  endtask

  task automatic push(input int n, input logic [DATA_W-1:0] base, input bit keep);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1;
      wr_data = base + DATA_W'(i);
      if (keep) exp_q.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic pop(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      chk({tag, " not empty"}, rd_empty, 0);
      chk({tag, " head word"}, rd_data, exp_q.pop_front());
      rd_en = 1;
    end
    @(negedge rd_clk);
    rd_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", rd_empty, 1);
    chk("R1 aempty", rd_aempty, 1);
    chk("R1 full", wr_full, 0);
    chk("R1 afull", wr_afull, 0);
  endtask

  task automatic t_single();
    int n = 0;
    push(1, 8'hA5, 1);
    while (rd_empty && n < 10) begin
      @(negedge rd_clk);
      n++;
    end
    chk("R3 empty falls within bound", int'(n <= 5), 1);
    pop(1, "R2 single");
    chk("R2 empty after last read", rd_empty, 1);
    settle();
  endtask

  task automatic t_fill();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge wr_clk);
      if (i == DEPTH - 1) chk("R4 not full before last slot", wr_full, 0);
      wr_en = 1;
      wr_data = 8'h10 + DATA_W'(i);
      exp_q.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en = 0;
    chk("R4 full on DEPTH-th write", wr_full, 1);
    push(3, 8'hEE, 0);
    chk("R5 still full after writes while full", wr_full, 1);
    wait_rd(6);
    pop(DEPTH, "R5 R2 drain");
    chk("R5 extra writes not stored", rd_empty, 1);
    while (wr_full && n < 10) begin
      @(negedge wr_clk);
      n++;
    end
    chk("R4 full falls within bound", int'(n <= 6), 1);
    settle();
  endtask

  task automatic t_thresh();
    wr_afull_lvl = 3;
    rd_aempty_lvl = 3;
    push(12, 8'h40, 1);
    chk("R7 afull off at 4 free", wr_afull, 0);
    push(1, 8'h4C, 1);
    chk("R7 afull on at 3 free", wr_afull, 1);
    wait_rd(6);
    chk("R8 aempty off at 13 stored", rd_aempty, 0);
    pop(9, "R2 partial");
    chk("R8 aempty off at 4 stored", rd_aempty, 0);
    pop(1, "R2 partial");
    chk("R8 aempty on at 3 stored", rd_aempty, 1);
    rd_aempty_lvl = 2;
    @(negedge rd_clk);
    chk("R10 aempty follows lowered level", rd_aempty, 0);
    rd_aempty_lvl = 3;
    @(negedge rd_clk);
    chk("R10 aempty follows raised level", rd_aempty, 1);
    wait_wr(8);
    chk("R7 afull off at 13 free", wr_afull, 0);
    wr_afull_lvl = 13;
    @(negedge wr_clk);
    chk("R10 afull follows raised level", wr_afull, 1);
    wr_afull_lvl = 12;
    @(negedge wr_clk);
    chk("R10 afull follows lowered level", wr_afull, 0);
    pop(3, "R2 tail");
    chk("R2 empty after tail", rd_empty, 1);
    wr_afull_lvl = 2;
    rd_aempty_lvl = 2;
    settle();
  endtask

  task automatic t_rd_empty();
    for (int i = 0; i < 5; i++) begin
      @(negedge rd_clk);
      rd_en = 1;
    end
    @(negedge rd_clk);
    rd_en = 0;
    chk("R6 empty kept after reads while empty", rd_empty, 1);
    push(1, 8'h5C, 1);
    wait_rd(6);
    pop(1, "R6 pointer unmoved");
    chk("R6 empty after single", rd_empty, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_wr(5);
    wr_rst_n = 1;
    rd_rst_n = 1;
    settle();
    t_reset();
    t_single();
    t_fill();
    t_thresh();
    t_rd_empty();
    finish_run();
  end
endmodule